// File: doc/BRIEF.md
# Transfer Completion and Status Interrupt Unit

This unit sits beside a transfer engine and handles everything that happens when work finishes. When a whole transfer request ends, the engine presents that request's 32-bit options word for one cycle. If the request asked for notification, the unit returns a completion report to the upstream channel controller. The report is a one-cycle valid pulse carrying a 6-bit completion code and the two request bits.

The unit also keeps two sticky status flags. One records that a transfer finished. The other records that the programmed register set moved into the engine's active registers. Each flag has an enable bit. A single level-sensitive interrupt line is high while any flag is set together with its enable. Software reaches the flags through a small register interface: a status view, an enable register, and a write-one-to-clear register.

Top module: `cmpl_status_unit`

## Requirements
- R1: One cycle after `req_done_i` is high with option bit 20 (interrupt request) or bit 22 (chain request) set, `cmpl_vld_o` is high for that cycle. In the same cycle `cmpl_code_o` equals option bits 17:12, `cmpl_irq_o` equals bit 20 and `cmpl_chain_o` equals bit 22.
- R2: A finished request with both bit 20 and bit 22 clear produces no report: `cmpl_vld_o` stays low.
- R3: Status bit 1 (transfer done) sets one cycle after any `req_done_i`, whatever the option bits are, and it stays set until it is cleared.
- R4: Status bit 0 (program set empty) sets one cycle after `prog_move_i` and stays set until it is cleared.
- R5: The status bits latch whether or not their enable bits are set.
- R6: `irq_o` is high exactly while (status & enable) is nonzero. It follows the register state in the same cycle.
- R7: Writing address 2 (clear) clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R8: If an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R9: After reset the status flags, the enables, the report outputs and `irq_o` are all 0.
- R10: Register map: address 0 reads the status in bits 1:0, and writes to it are ignored. Address 1 is the read/write enable register in bits 1:0. Address 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_done_i | input | 1 | Whole transfer request finished this cycle |
| req_opt_i | input | 32 | Options word of the finishing request |
| prog_move_i | input | 1 | Programmed set moved to the active registers |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cmpl_vld_o | output | 1 | Completion report valid pulse |
| cmpl_code_o | output | 6 | Completion code |
| cmpl_irq_o | output | 1 | Report carries an interrupt request |
| cmpl_chain_o | output | 1 | Report carries a chain request |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench drives requests with each mix of the two request bits. That includes a request with both bits clear, which a design that reports every completion would answer with a stray pulse. It also drives back-to-back requests, where a design that holds or drops the valid pulse would lose or duplicate a code. Transfer-done events arrive while their enable is off, to catch a design that latches status only when it is enabled. A clear is issued in the same cycle as a new event, to expose a design that lets the clear win. The bench also checks that clearing with zero data bits, and writing to the status address, leave the flags untouched.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
  localparam int unsigned OPT_W     = 32;
  localparam int unsigned CODE_W    = 6;
  localparam int unsigned CODE_LSB  = 12;
  localparam int unsigned IRQ_BIT   = 20;
  localparam int unsigned CHAIN_BIT = 22;
  localparam int unsigned N_STS     = 2;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned DATA_W    = 32;

  // status bit positions
  localparam int unsigned STS_PROG = 0;
  localparam int unsigned STS_DONE = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STS = 2'd0,
    ADDR_EN  = 2'd1,
    ADDR_CLR = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              irq;
    logic              chain;
  } cmpl_rpt_t;
endpackage

// File: rtl/cmpl_report.sv
module cmpl_report
  import cmpl_pkg::*;
#(
  parameter int unsigned OW   = OPT_W,
  parameter int unsigned CW   = CODE_W,
  parameter int unsigned CLSB = CODE_LSB,
  parameter int unsigned IB   = IRQ_BIT,
  parameter int unsigned CB   = CHAIN_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [OW-1:0] opt_i,
  output logic          vld_o,
  output logic [CW-1:0] code_o,
  output logic          irq_o,
  output logic          chain_o
);
  logic want_rpt;
  assign want_rpt = done_i & (opt_i[IB] | opt_i[CB]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      code_o  <= '0;
      irq_o   <= 1'b0;
      chain_o <= 1'b0;
    end else begin
      vld_o <= want_rpt;
      if (want_rpt) begin
        code_o  <= opt_i[CLSB +: CW];
        irq_o   <= opt_i[IB];
        chain_o <= opt_i[CB];
      end else begin
        code_o  <= '0;
        irq_o   <= 1'b0;
        chain_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sts_regs.sv
module sts_regs
  import cmpl_pkg::*;
#(
  parameter int unsigned N = N_STS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         en_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] en_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic clr;
    assign clr = clr_we_i & wdata_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_o[g] <= 1'b0;
      end else if (evt_i[g]) begin
        sts_o[g] <= 1'b1;  // event beats clear
      end else if (clr) begin
        sts_o[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/cmpl_status_unit.sv
module cmpl_status_unit
  import cmpl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_done_i,
  input  logic [OPT_W-1:0]  req_opt_i,
  input  logic              prog_move_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cmpl_vld_o,
  output logic [CODE_W-1:0] cmpl_code_o,
  output logic              cmpl_irq_o,
  output logic              cmpl_chain_o,
  output logic              irq_o
);
  logic [N_STS-1:0] evt, sts_q, en_q;
  logic             en_we, clr_we;

  assign evt[STS_PROG] = prog_move_i;
  assign evt[STS_DONE] = req_done_i;
  assign en_we  = reg_we_i & (reg_addr_i == ADDR_EN);
  assign clr_we = reg_we_i & (reg_addr_i == ADDR_CLR);

  cmpl_report i_report (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (req_done_i),
    .opt_i   (req_opt_i),
    .vld_o   (cmpl_vld_o),
    .code_o  (cmpl_code_o),
    .irq_o   (cmpl_irq_o),
    .chain_o (cmpl_chain_o)
  );

  sts_regs i_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .en_we_i  (en_we),
    .clr_we_i (clr_we),
    .wdata_i  (reg_wdata_i[N_STS-1:0]),
    .sts_o    (sts_q),
    .en_o     (en_q)
  );

  assign irq_o = |(sts_q & en_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_STS: reg_rdata_o[N_STS-1:0] = sts_q;
      ADDR_EN:  reg_rdata_o[N_STS-1:0] = en_q;
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cmpl_status_chk.sv
module cmpl_status_chk
  import cmpl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_done_i,
  input logic [OPT_W-1:0]  req_opt_i,
  input logic              prog_move_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              cmpl_vld_o,
  input logic [CODE_W-1:0] cmpl_code_o,
  input logic              irq_o,
  input logic [N_STS-1:0]  sts_q
);
  logic ask;
  assign ask = req_opt_i[IRQ_BIT] | req_opt_i[CHAIN_BIT];

  p_report_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_i && ask |=> cmpl_vld_o && cmpl_code_o == $past(req_opt_i[CODE_LSB +: CODE_W]));

  p_no_report_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_done_i && ask) |=> !cmpl_vld_o);

  p_done_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_i |=> sts_q[STS_DONE]);

  p_prog_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_move_i |=> sts_q[STS_PROG]);

  p_irq_needs_sts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts_q != '0);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == ADDR_CLR && reg_wdata_i[STS_DONE] && !req_done_i
    |=> !sts_q[STS_DONE]);

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q[STS_DONE] && !(reg_we_i && reg_addr_i == ADDR_CLR) |=> sts_q[STS_DONE]);
endmodule

bind cmpl_status_unit cmpl_status_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_done_i  (req_done_i),
  .req_opt_i   (req_opt_i),
  .prog_move_i (prog_move_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .cmpl_vld_o  (cmpl_vld_o),
  .cmpl_code_o (cmpl_code_o),
  .irq_o       (irq_o),
  .sts_q       (sts_q)
);

// File: tb/test_cmpl_status_unit.sv
module test_cmpl_status_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_done_i = 1'b0;
  logic [31:0] req_opt_i = '0;
  logic        prog_move_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        cmpl_vld_o;
  logic [5:0]  cmpl_code_o;
  logic        cmpl_irq_o, cmpl_chain_o, irq_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];  // {code, irq, chain}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cmpl_status_unit i_cmpl_status_unit (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected reports
  always @(negedge clk_i) begin
    if (rst_ni && cmpl_vld_o) begin
      if (exp_q.size() == 0) check("R2 stray report", 1, 0);
      else check("R1 report", {24'd0, cmpl_code_o, cmpl_irq_o, cmpl_chain_o}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic send_done(logic [5:0] code, logic irq, logic chain);
    req_done_i = 1'b1;
    req_opt_i  = '0;
    req_opt_i[17:12] = code;
    req_opt_i[20] = irq;
    req_opt_i[22] = chain;
    req_opt_i[5]  = 1'b1;  // unrelated bit
    if (irq || chain) exp_q.push_back({code, irq, chain});
    @(negedge clk_i);
    req_done_i = 1'b0;
    req_opt_i  = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    check("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    rd(0, d); check("R9 status", d, 0);
    rd(1, d); check("R9 enable", d, 0);
    check("R9 irq", {31'd0, irq_o}, 0);
    check("R9 vld", {31'd0, cmpl_vld_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 interrupt only; R3/R5 latch without enable
    send_done(6'h2A, 1'b1, 1'b0);
    rd(0, d); check("R3 done bit", d, 32'h2);
    check("R5 irq off with enable 0", {31'd0, irq_o}, 0);
    // R2 neither bit
    send_done(6'h05, 1'b0, 1'b0);
    check("R2 no vld", {31'd0, cmpl_vld_o}, 0);
    // R1 chain only, both bits, back to back
    send_done(6'h3F, 1'b0, 1'b1);
    send_done(6'h00, 1'b1, 1'b1);
    send_done(6'h11, 1'b1, 1'b0);
    @(negedge clk_i);
    check("R1 pulse ends", {31'd0, cmpl_vld_o}, 0);
    check("R1 queue drained", exp_q.size(), 0);

    // R4
    prog_move_i = 1'b1; @(negedge clk_i); prog_move_i = 1'b0;
    rd(0, d); check("R4 status both", d, 32'h3);

    // R6 / R10 enable
    wr(1, 32'h2);
    rd(1, d); check("R10 enable readback", d, 32'h2);
    check("R6 irq on", {31'd0, irq_o}, 1);
    // R7 clear with zero: no effect
    wr(2, 32'h0);
    rd(0, d); check("R7 zero clear", d, 32'h3);
    // R10 status write ignored
    wr(0, 32'h0);
    rd(0, d); check("R10 status write ignored", d, 32'h3);
    rd(2, d); check("R10 clear reads 0", d, 0);
    // R7 clear done bit
    wr(2, 32'h2);
    rd(0, d); check("R7 cleared", d, 32'h1);
    check("R6 irq off", {31'd0, irq_o}, 0);
    // R6 enable other bit
    wr(1, 32'h1);
    check("R6 irq prog", {31'd0, irq_o}, 1);
    // R8 event wins over clear
    prog_move_i = 1'b1;
    wr(2, 32'h1);
    prog_move_i = 1'b0;
    rd(0, d); check("R8 event wins", d, 32'h1);
    wr(2, 32'h1);
    rd(0, d); check("R7 cleared prog", d, 0);
    check("R6 irq drops", {31'd0, irq_o}, 0);

    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule